// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Port Control

This block is a two-port synchronous static RAM model, eight bits wide, with the read/write and enable control for each port. Every control input is captured on the rising clock edge. Two chip enables select the port: one is active low and the other is active high. A read/write select picks the operation. An output enable gates the data outputs at once, with no clock involved. A per-port mode input chooses between flow-through output, where read data is shown in the cycle after the edge, and pipelined output, which adds one output register.

The high-impedance state of a real device is modelled by a drive flag. When the flag is low the data output is forced to zero. The chip-enable qualification of the output path passes through one register in flow-through mode and two registers in pipelined mode. A deselect therefore removes the output one cycle later when the port is pipelined. Both ports share one behavioural array. In the full part the depth is 32K or 64K words; here it is a parameter with a small default. If both ports write one address on the same edge, the left port's data is kept.

Top module: `dpr_sync_top`

## Requirements
- R1: An edge where the active-low enable is 1 or the active-high enable is 0 deselects the port. The array is not written. In flow-through mode the drive flag is 0 in the cycle after that edge. After two such edges in a row, the drive flag is 0 in either mode.
- R2: An edge with the active-low enable 0, the active-high enable 1 and read/write 0 stores the data input at the address input.
- R3: Flow-through mode has mode input 0. An edge with both enables asserted and read/write 1 is a read. In the cycle after that edge, the drive flag is 1 and the data output holds the addressed word, provided the output enable (active low) is 0. The word includes any write by the other port on that same edge.
- R4: Pipelined mode has mode input 1. The read data and drive flag of R3 appear one cycle later, in the cycle after the following edge.
- R5: While the output enable is 1, the drive flag is 0 and the data output is 0, with no clock edge needed. Driving it back to 0 restores the output within the same cycle.
- R6: In pipelined mode, a read followed by a deselect on the next edge still drives the read word during the cycle after the deselect edge. The drive flag falls one cycle later.
- R7: Whenever the drive flag is 0, the data output is 0.
- R8: When both ports write the same address on one edge, the array keeps the left port's data.
- R9: An edge with reset low clears every enable stage and performs no write. After reset releases, the drive flag stays 0 until a read reaches the output.
- R10: A write never drives the output. After two write edges in a row, the drive flag is 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_ce_n | input | 1 | Left enable, active low |
| l_ce | input | 1 | Left enable, active high |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_pipe | input | 1 | Left output mode: 1 pipelined, 0 flow-through |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, 0 when not driven |
| l_drv | output | 1 | Left drive flag (1 = outputs driven) |
| r_ce_n | input | 1 | Right enable, active low |
| r_ce | input | 1 | Right enable, active high |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_pipe | input | 1 | Right output mode: 1 pipelined, 0 flow-through |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, 0 when not driven |
| r_drv | output | 1 | Right drive flag (1 = outputs driven) |

## Verification
Two kinds of cross-port event can land on the same edge. One is a write by each port to a single address. The other is a read on one port while the other port writes the address being read. Random stimulus confines both ports to eight addresses with frequent enables, so both cases occur often, in flow-through, pipelined and mixed modes. A bench model applies the right port's write before the left one's, then reads the word for each port. Each output is compared mid-cycle with the model's value, either from the same edge or delayed one edge by the mode. Directed cases pin down the left-wins collision and the write-visible-to-same-edge read with literal values.

// File: rtl/dpr_pkg.sv
// Package: shared command type and the decode used by every port.
// Assumes: enables and read/write are sampled together on one edge.
package dpr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    // Classify one port's sampled controls into a command.
    function automatic cmd_e cmd_decode(input logic ce_n, input logic ce, input logic rw);
        cmd_e c;
        if (ce_n || !ce) begin
            c = CMD_NOP;
        end else if (rw) begin
            c = CMD_READ;
        end else begin
            c = CMD_WRITE;
        end
        return c;
    endfunction

endpackage

// File: rtl/dpr_en_pipe.sv
// Module: chain of registers carrying the "read may drive" qualifier.
// Tap 0 is one stage after the edge, tap DEPTH-1 is DEPTH stages after.
// Assumes: synchronous active-low reset clears every stage.
module dpr_en_pipe #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_in,
    output logic [DEPTH-1:0] qual_tap
);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage captures the decoded qualifier.
                always_ff @(posedge clk) begin
                    if (!rst_n) qual_tap[0] <= 1'b0;
                    else        qual_tap[0] <= qual_in;
                end
            end else begin : g_next
                // Later stages shift the previous stage on.
                always_ff @(posedge clk) begin
                    if (!rst_n) qual_tap[i] <= 1'b0;
                    else        qual_tap[i] <= qual_tap[i-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dpr_mem_array.sv
// Module: behavioural storage shared by two ports; side A wins a
// same-address write on one edge. Reads are combinational.
// Assumes: content is not reset; only written words are read.
module dpr_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_waddr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [ADDR_W-1:0] a_raddr,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_waddr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [ADDR_W-1:0] b_raddr,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write both ports; A is applied last so it wins a collision.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_waddr] <= b_wdata;
        if (a_we) mem[a_waddr] <= a_wdata;
    end

    // Read ports see the array as left by the latest edge.
    always_comb begin
        a_rdata = mem[a_raddr];
        b_rdata = mem[b_raddr];
    end

endmodule

// File: rtl/dpr_port_ctrl.sv
// Module: control for one port. Decodes the sampled enables, issues the
// write, holds the read address, keeps an optional output register and
// selects the flow-through or pipelined output path. The output enable
// gates the result combinationally.
// Assumes: the array applies writes on the same edge the controls are seen.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] arr_raddr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              drv
);

    localparam int STAGES = 2;

    cmd_e              cmd;
    logic [ADDR_W-1:0] raddr_q;
    logic [DATA_W-1:0] pdata_q;
    logic [STAGES-1:0] rd_tap;
    logic              path_ok;
    logic [DATA_W-1:0] path_data;

    // Decode the controls as they stand at the coming edge.
    always_comb begin
        cmd       = cmd_decode(ce_n, ce, rw);
        arr_we    = (cmd == CMD_WRITE) && rst_n;
        arr_waddr = addr;
        arr_wdata = din;
        arr_raddr = raddr_q;
    end

    // Hold the read address of the latest edge.
    always_ff @(posedge clk) begin
        if (!rst_n) raddr_q <= '0;
        else        raddr_q <= addr;
    end

    // Output register used by the pipelined path.
    always_ff @(posedge clk) begin
        if (!rst_n) pdata_q <= '0;
        else        pdata_q <= arr_rdata;
    end

    dpr_en_pipe #(.DEPTH(STAGES)) u_en_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_in  (cmd == CMD_READ),
        .qual_tap (rd_tap)
    );

    // Pick the path for the mode, then apply the asynchronous gate.
    always_comb begin
        if (pipe) begin
            path_ok   = rd_tap[STAGES-1];
            path_data = pdata_q;
        end else begin
            path_ok   = rd_tap[0];
            path_data = arr_rdata;
        end
        drv  = path_ok && !oe_n;
        dout = drv ? path_data : '0;
    end

endmodule

// File: rtl/dpr_sync_top.sv
// Module: two-port synchronous RAM; left and right port controls over
// one shared array. Left wins a same-edge write to one address.
// Assumes: both ports run on one clock.
module dpr_sync_top #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_ce,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_drv,
    input  logic              r_ce_n,
    input  logic              r_ce,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_drv
);

    logic              l_we, r_we;
    logic [ADDR_W-1:0] l_wa, r_wa, l_ra, r_ra;
    logic [DATA_W-1:0] l_wd, r_wd, l_rd, r_rd;

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
        .clk(clk), .rst_n(rst_n),
        .ce_n(l_ce_n), .ce(l_ce), .rw(l_rw), .oe_n(l_oe_n), .pipe(l_pipe),
        .addr(l_addr), .din(l_din),
        .arr_we(l_we), .arr_waddr(l_wa), .arr_wdata(l_wd),
        .arr_raddr(l_ra), .arr_rdata(l_rd),
        .dout(l_dout), .drv(l_drv)
    );

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
        .clk(clk), .rst_n(rst_n),
        .ce_n(r_ce_n), .ce(r_ce), .rw(r_rw), .oe_n(r_oe_n), .pipe(r_pipe),
        .addr(r_addr), .din(r_din),
        .arr_we(r_we), .arr_waddr(r_wa), .arr_wdata(r_wd),
        .arr_raddr(r_ra), .arr_rdata(r_rd),
        .dout(r_dout), .drv(r_drv)
    );

    dpr_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk),
        .a_we(l_we), .a_waddr(l_wa), .a_wdata(l_wd), .a_raddr(l_ra), .a_rdata(l_rd),
        .b_we(r_we), .b_waddr(r_wa), .b_wdata(r_wd), .b_raddr(r_ra), .b_rdata(r_rd)
    );

endmodule

// File: rtl/dpr_sync_chk.sv
// Module: property checker for the two-port RAM, bound to the top.
// Assumes: observes top-level ports only.
module dpr_sync_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n,
    input logic              l_ce,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic              l_pipe,
    input logic [DATA_W-1:0] l_dout,
    input logic              l_drv,
    input logic              r_ce_n,
    input logic              r_ce,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic              r_pipe,
    input logic [DATA_W-1:0] r_dout,
    input logic              r_drv
);

    logic l_off, r_off, l_rd, r_rd, l_wr, r_wr;
    assign l_off = l_ce_n || !l_ce;
    assign r_off = r_ce_n || !r_ce;
    assign l_rd  = !l_off && l_rw;
    assign r_rd  = !r_off && r_rw;
    assign l_wr  = !l_off && !l_rw;
    assign r_wr  = !r_off && !r_rw;

    p_desel_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_off && $past(l_off)) |=> !l_drv);
    p_desel_off_r_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_off && $past(r_off)) |=> !r_drv);
    p_ft_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> (l_drv || l_oe_n || l_pipe));
    p_pipe_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |-> ##2 (l_drv || l_oe_n || !l_pipe));
    p_oe_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_oe_n |-> !l_drv) and (r_oe_n |-> !r_drv));
    p_zero_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_drv |-> (l_dout == '0)) and (!r_drv |-> (r_dout == '0)));
    p_write_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && $past(r_wr)) |=> !r_drv);
    p_ft_read_r_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |=> (r_drv || r_oe_n || r_pipe));
    p_write_no_drive_l_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && $past(l_wr)) |=> !l_drv);

endmodule

bind dpr_sync_top dpr_sync_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_ce(l_ce), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_dout(l_dout), .l_drv(l_drv),
    .r_ce_n(r_ce_n), .r_ce(r_ce), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
    .r_dout(r_dout), .r_drv(r_drv)
);

// File: tb/dpr_sync_top_tb.sv
`timescale 1ns/1ps
module dpr_sync_top_tb;

    localparam int  AW  = 10;
    localparam int  DW  = 8;
    localparam real TCK = 4.0;

    logic clk = 1'b0;
    logic rst_n;
    logic          ce_n [2];
    logic          ce   [2];
    logic          rw   [2];
    logic          oe_n [2];
    logic          pipe [2];
    logic [AW-1:0] addr [2];
    logic [DW-1:0] din  [2];
    logic [DW-1:0] l_dout, r_dout;
    logic          l_drv, r_drv;

    int n_checks = 0;
    int n_err    = 0;

    always #(TCK/2) clk = ~clk;

    dpr_sync_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(ce_n[0]), .l_ce(ce[0]), .l_rw(rw[0]), .l_oe_n(oe_n[0]), .l_pipe(pipe[0]),
        .l_addr(addr[0]), .l_din(din[0]), .l_dout(l_dout), .l_drv(l_drv),
        .r_ce_n(ce_n[1]), .r_ce(ce[1]), .r_rw(rw[1]), .r_oe_n(oe_n[1]), .r_pipe(pipe[1]),
        .r_addr(addr[1]), .r_din(din[1]), .r_dout(r_dout), .r_drv(r_drv)
    );

    // Bench model
    logic [DW-1:0] mdl [1 << AW];
    bit            cur_ok [2];
    bit            prv_ok [2];
    logic [DW-1:0] cur_d  [2];
    logic [DW-1:0] prv_d  [2];
    string         cur_tag [2];
    string         prv_tag [2];

    function automatic bit is_sel(int p);
        return !ce_n[p] && ce[p];
    endfunction

    function automatic logic [DW-1:0] get_dout(int p);
        return (p == 0) ? l_dout : r_dout;
    endfunction

    function automatic logic get_drv(int p);
        return (p == 0) ? l_drv : r_drv;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_cmd(int p, int kind, int a, int d);
        ce_n[p] = (kind == 0);
        ce[p]   = (kind != 0);
        rw[p]   = (kind == 2);
        addr[p] = AW'(a);
        din[p]  = DW'(d);
    endtask

    // One edge: update the model after the edge, then compare mid-cycle.
    task automatic step();
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            prv_ok[p]  = cur_ok[p];
            prv_d[p]   = cur_d[p];
            prv_tag[p] = cur_tag[p];
        end
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                cur_ok[p] = 0; prv_ok[p] = 0;
                cur_d[p] = '0; prv_d[p] = '0;
                cur_tag[p] = "R9"; prv_tag[p] = "R9";
            end
        end else begin
            if (is_sel(1) && !rw[1]) mdl[addr[1]] = din[1];
            if (is_sel(0) && !rw[0]) mdl[addr[0]] = din[0];
            for (int p = 0; p < 2; p++) begin
                cur_ok[p] = is_sel(p) && rw[p];
                cur_d[p]  = mdl[addr[p]];
                if (!is_sel(p))   cur_tag[p] = "R1";
                else if (!rw[p])  cur_tag[p] = "R10";
                else              cur_tag[p] = "R3";
            end
        end
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            bit            eok;
            logic [DW-1:0] ed;
            string         tg;
            eok = pipe[p] ? prv_ok[p] : cur_ok[p];
            ed  = pipe[p] ? prv_d[p]  : cur_d[p];
            tg  = pipe[p] ? prv_tag[p] : cur_tag[p];
            if (pipe[p] && tg == "R3") tg = "R4";
            if (oe_n[p]) tg = "R5";
            eok = eok && !oe_n[p];
            if (!eok) ed = '0;
            check({tg, " drive"}, DW'(get_drv(p)), DW'(eok));
            check({tg, " data"}, get_dout(p), ed);
        end
    endtask

    initial begin
        #(TCK * 200000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        for (int p = 0; p < 2; p++) begin
            set_cmd(p, 0, 0, 0);
            oe_n[p] = 1'b0;
            pipe[p] = 1'b0;
            cur_ok[p] = 0; prv_ok[p] = 0; cur_d[p] = '0; prv_d[p] = '0;
            cur_tag[p] = "R9"; prv_tag[p] = "R9";
        end
        repeat (3) step();
        rst_n = 1'b1;
        // R9: outputs quiet after reset
        check("R9 left drive", DW'(l_drv), '0);
        check("R9 right drive", DW'(r_drv), '0);

        // R2: preload addresses 0..7 through the left port
        for (int a = 0; a < 8; a++) begin
            set_cmd(0, 1, a, 8'h10 + a);
            step();
        end
        set_cmd(0, 2, 5, 0);
        step();
        check("R2 preload read", l_dout, 8'h15);

        // R8: same-edge writes to address 3, left kept
        set_cmd(0, 1, 3, 8'hA5);
        set_cmd(1, 1, 3, 8'h5A);
        step();
        set_cmd(0, 2, 3, 0);
        set_cmd(1, 0, 0, 0);
        step();
        check("R8 collision", l_dout, 8'hA5);

        // R3: right reads address 6 while left writes it on the same edge
        set_cmd(0, 1, 6, 8'h66);
        set_cmd(1, 2, 6, 0);
        step();
        check("R3 write-visible read", r_dout, 8'h66);

        // R5: output enable removes the drive mid-cycle, no clock
        set_cmd(0, 2, 6, 0);
        set_cmd(1, 0, 0, 0);
        step();
        oe_n[0] = 1'b1;
        #(TCK/8);
        check("R5 oe high drive", DW'(l_drv), '0);
        check("R5 oe high data", l_dout, '0);
        oe_n[0] = 1'b0;
        #(TCK/8);
        check("R5 oe low drive", DW'(l_drv), 8'h01);
        check("R5 oe low data", l_dout, 8'h66);

        // R4 and R6: pipelined read then deselect
        pipe[0] = 1'b1;
        set_cmd(0, 0, 0, 0);
        step();
        step();
        set_cmd(0, 2, 2, 0);
        step();
        check("R4 not yet driven", DW'(l_drv), '0);
        set_cmd(0, 0, 0, 0);
        step();
        check("R6 driven after deselect", l_dout, 8'h12);
        step();
        check("R6 off one cycle later", DW'(l_drv), '0);
        pipe[0] = 1'b0;

        // Random phases: flow-through, pipelined, mixed
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < 2; p++) begin
                int k;
                k = ($urandom % 6 == 0) ? 0 : (($urandom % 2 == 0) ? 1 : 2);
                set_cmd(p, k, $urandom % 8, $urandom % 256);
                if (k == 0 && ($urandom % 2 == 0)) begin
                    ce_n[p] = 1'b0;
                    ce[p]   = 1'b0;
                end
                oe_n[p] = ($urandom % 8 == 0);
                if (i < 1000)      pipe[p] = 1'b0;
                else if (i < 2000) pipe[p] = 1'b1;
                else               pipe[p] = ($urandom % 2 == 1);
            end
            step();
        end

        // R9: reset during an active read quiets the output
        for (int p = 0; p < 2; p++) begin
            oe_n[p] = 1'b0;
            set_cmd(p, 2, 1, 0);
        end
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R9 reset left", DW'(l_drv), '0);
        check("R9 reset right", DW'(r_drv), '0);
        step();

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule